// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block produces the second operand of a data-processing datapath together with the shifter carry-out. A 32-bit value is shifted left, shifted right logically, shifted right arithmetically or rotated right. The shift amount comes from one of three sources picked by `src_i`:

- a 5-bit immediate field;
- the low byte of a register;
- a rotated-immediate mode that builds the operand from a zero-extended 8-bit constant, rotated right by twice a 4-bit field.

The datapath is purely combinational. `clk_i` and `rst_ni` only sample the embedded assertions. Zero and oversized amounts have special meanings that depend on the source. The carry-out always follows one rule: it is the last bit moved out of the value, or the incoming carry when nothing moves. The ALU and the register file sit outside this block.

Top module: `opsh_barrel`

## Requirements
- R1: `type_i` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. `src_i` encodes 0 = 5-bit immediate amount, 1 = register amount, 2 = rotated immediate, and 3 behaves as 0. For amounts 1..31 the result is the shifted value, and `carry_o` is the last bit shifted out (for rotate: result bit 31).
- R2: Any effective amount of zero passes `value_i` unchanged and copies `carry_i` to `carry_o`. This covers a logical left immediate of 0 and any register amount of 0.
- R3: With an immediate amount of 0, a logical right shift acts as a shift by 32 (result 0, carry = bit 31). An arithmetic right shift also acts as a shift by 32 (every result bit = bit 31, carry = bit 31).
- R4: With an immediate amount of 0, rotate right becomes a one-bit rotate through the carry: the result is `{carry_i, value_i[31:1]}` and the carry is `value_i[0]`.
- R5: In register mode the full 8-bit amount is used, so amounts from 32 up to 255 are honoured rather than wrapped to 5 bits.
- R6: In register mode a logical shift by exactly 32 gives 0 with carry = bit 0 (left) or bit 31 (right). Amounts of 33 or more give 0 with carry 0.
- R7: In register mode an arithmetic right shift by 32 or more gives all bits equal to bit 31, with carry = bit 31.
- R8: In register mode a rotate uses the amount modulo 32. A nonzero amount whose remainder is 0 leaves the value unchanged with carry = bit 31.
- R9: In rotated-immediate mode the operand is `rot_imm_i` zero-extended and rotated right by 2 × `rot_fld_i`. The carry is result bit 31, or `carry_i` when the field is 0. `value_i` and `type_i` have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for assertions only |
| rst_ni | input | 1 | Active-low asynchronous reset, gates assertions |
| src_i | input | 2 | Amount source select |
| type_i | input | 2 | Shift type |
| value_i | input | 32 | Value to shift |
| carry_i | input | 1 | Incoming carry flag |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the amount register |
| rot_imm_i | input | 8 | Constant for rotated-immediate mode |
| rot_fld_i | input | 4 | Half rotate amount for rotated-immediate mode |
| operand_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Amount reinterpretation and carry selection resolve in the same evaluation. An immediate zero must be turned into a shift by 32 or a rotate through carry, and the matching carry source must be picked at the same time. Likewise, a large register amount must be clamped while the carry switches between bit 0, bit 31 and zero.

The bench provokes these cases with values whose bit 0, bit 31 and `carry_i` all differ, so a wrong carry source shows up at once. Each result is judged against a model that shifts one bit at a time.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_type_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_ROT = 2'd2,
    SRC_RSV = 2'd3
  } amt_src_e;

  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } sh_kind_e;
endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int ROT_IMM_W = 8,
  parameter int ROT_FLD_W = 4,
  localparam int AMT_W    = $clog2(DATA_W + 2),
  localparam int LOG_W    = $clog2(DATA_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           src_i,
  input  logic [1:0]           type_i,
  input  logic [DATA_W-1:0]    value_i,
  input  logic [IMM_AMT_W-1:0] imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic [ROT_IMM_W-1:0] rot_imm_i,
  input  logic [ROT_FLD_W-1:0] rot_fld_i,
  output logic [DATA_W-1:0]    val_o,
  output sh_kind_e             kind_o,
  output logic [AMT_W-1:0]     amt_o
);
  localparam logic [AMT_W-1:0]     FULL_A  = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0]     OVER_A  = AMT_W'(DATA_W + 1);
  localparam logic [REG_AMT_W-1:0] FULL_R  = REG_AMT_W'(DATA_W);
  localparam logic [REG_AMT_W-1:0] OVER_R  = REG_AMT_W'(DATA_W + 1);

  logic [LOG_W-1:0] reg_mod;
  assign reg_mod = reg_amt_i[LOG_W-1:0];

  always_comb begin
    val_o  = value_i;
    kind_o = K_LSL;
    amt_o  = '0;
    case (amt_src_e'(src_i))
      SRC_REG: begin
        case (sh_type_e'(type_i))
          SH_LSL: begin
            kind_o = K_LSL;
            amt_o  = (reg_amt_i > OVER_R) ? OVER_A : AMT_W'(reg_amt_i);
          end
          SH_LSR: begin
            kind_o = K_LSR;
            amt_o  = (reg_amt_i > OVER_R) ? OVER_A : AMT_W'(reg_amt_i);
          end
          SH_ASR: begin
            kind_o = K_ASR;
            amt_o  = (reg_amt_i > FULL_R) ? FULL_A : AMT_W'(reg_amt_i);
          end
          default: begin
            kind_o = K_ROR;
            if (reg_amt_i == '0)    amt_o = '0;
            else if (reg_mod == '0) amt_o = FULL_A;
            else                    amt_o = AMT_W'(reg_mod);
          end
        endcase
      end
      SRC_ROT: begin
        // operand built from the constant; value_i and type_i unused
        val_o  = {{(DATA_W-ROT_IMM_W){1'b0}}, rot_imm_i};
        kind_o = K_ROR;
        amt_o  = AMT_W'({rot_fld_i, 1'b0});
      end
      default: begin
        case (sh_type_e'(type_i))
          SH_LSL: begin
            kind_o = K_LSL;
            amt_o  = AMT_W'(imm_amt_i);
          end
          SH_LSR: begin
            kind_o = K_LSR;
            amt_o  = (imm_amt_i == '0) ? FULL_A : AMT_W'(imm_amt_i);
          end
          SH_ASR: begin
            kind_o = K_ASR;
            amt_o  = (imm_amt_i == '0) ? FULL_A : AMT_W'(imm_amt_i);
          end
          default: begin
            kind_o = (imm_amt_i == '0) ? K_RRX : K_ROR;
            amt_o  = (imm_amt_i == '0) ? AMT_W'(1) : AMT_W'(imm_amt_i);
          end
        endcase
      end
    endcase
  end

  a_r5_amt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amt_o <= OVER_A);

  a_r6_logic_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_REG && !type_i[1] && reg_amt_i > OVER_R) |-> amt_o == OVER_A);

  a_r7_asr_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_REG && type_i == SH_ASR) |-> amt_o <= FULL_A);

  a_r8_ror_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_REG && type_i == SH_ROR && reg_amt_i != '0)
      |-> (amt_o != '0 && amt_o <= FULL_A));
endmodule

// File: rtl/opsh_core.sv
module opsh_core
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] val_i,
  input  sh_kind_e          kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam logic [AMT_W-1:0] FULL_A = AMT_W'(DATA_W);

  logic        [DATA_W:0]   wide_l;
  logic        [DATA_W:0]   wide_r;
  logic signed [DATA_W:0]   wide_a;
  logic        [DATA_W-1:0] rot;
  logic        [AMT_W-1:0]  back_amt;

  // one spare bit beside the value catches the last bit shifted out
  assign wide_l   = {1'b0, val_i} << amt_i;
  assign wide_r   = {val_i, 1'b0} >> amt_i;
  assign wide_a   = $signed({val_i, 1'b0}) >>> amt_i;
  assign back_amt = FULL_A - amt_i;
  assign rot      = (val_i >> amt_i) | (val_i << back_amt);

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (kind_i == K_RRX) begin
      res_o   = {carry_i, val_i[DATA_W-1:1]};
      carry_o = val_i[0];
    end else if (amt_i != '0) begin
      case (kind_i)
        K_LSL: begin res_o = wide_l[DATA_W-1:0]; carry_o = wide_l[DATA_W]; end
        K_LSR: begin res_o = wide_r[DATA_W:1];   carry_o = wide_r[0];      end
        K_ASR: begin res_o = wide_a[DATA_W:1];   carry_o = wide_a[0];      end
        default: begin res_o = rot;              carry_o = rot[DATA_W-1];  end
      endcase
    end
  end

  a_r2_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amt_i == '0 && kind_i != K_RRX) |-> (res_o == val_i && carry_o == carry_i));

  a_r4_rrx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_RRX) |-> (res_o[DATA_W-1] == carry_i && carry_o == val_i[0]));

  a_r6_over_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kind_i == K_LSL || kind_i == K_LSR) && amt_i > FULL_A)
      |-> (res_o == '0 && !carry_o));

  a_r7_asr_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_ASR && amt_i != '0) |-> res_o[DATA_W-1] == val_i[DATA_W-1]);
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int ROT_IMM_W = 8,
  parameter int ROT_FLD_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           src_i,
  input  logic [1:0]           type_i,
  input  logic [DATA_W-1:0]    value_i,
  input  logic                 carry_i,
  input  logic [IMM_AMT_W-1:0] imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic [ROT_IMM_W-1:0] rot_imm_i,
  input  logic [ROT_FLD_W-1:0] rot_fld_i,
  output logic [DATA_W-1:0]    operand_o,
  output logic                 carry_o
);
  localparam int AMT_W = $clog2(DATA_W + 2);

  logic [DATA_W-1:0] dec_val;
  sh_kind_e          dec_kind;
  logic [AMT_W-1:0]  dec_amt;

  opsh_decode #(
    .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W),
    .ROT_IMM_W(ROT_IMM_W), .ROT_FLD_W(ROT_FLD_W)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .type_i(type_i),
    .value_i(value_i), .imm_amt_i(imm_amt_i), .reg_amt_i(reg_amt_i),
    .rot_imm_i(rot_imm_i), .rot_fld_i(rot_fld_i),
    .val_o(dec_val), .kind_o(dec_kind), .amt_o(dec_amt)
  );

  opsh_core #(.DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i(dec_val), .kind_i(dec_kind),
    .amt_i(dec_amt), .carry_i(carry_i), .res_o(operand_o), .carry_o(carry_o)
  );

  a_r3_lsr_zero_is_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != SRC_REG && src_i != SRC_ROT && type_i == SH_LSR && imm_amt_i == '0)
      |-> (operand_o == '0 && carry_o == value_i[DATA_W-1]));

  a_r9_rot_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_ROT) |-> $countones(operand_o) == $countones(rot_imm_i));

  a_r9_rot_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_ROT && rot_fld_i != '0) |-> carry_o == operand_o[DATA_W-1]);
endmodule

// File: tb/opsh_barrel_bench.sv
module opsh_barrel_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  src_i = '0;
  logic [1:0]  type_i = '0;
  logic [31:0] value_i = '0;
  logic        carry_i = 1'b0;
  logic [4:0]  imm_amt_i = '0;
  logic [7:0]  reg_amt_i = '0;
  logic [7:0]  rot_imm_i = '0;
  logic [3:0]  rot_fld_i = '0;
  logic [31:0] operand_o;
  logic        carry_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  opsh_barrel u_opsh_barrel (
    .clk_i, .rst_ni, .src_i, .type_i, .value_i, .carry_i, .imm_amt_i,
    .reg_amt_i, .rot_imm_i, .rot_fld_i, .operand_o, .carry_o
  );

  // bit-at-a-time reference: n single steps of the chosen type
  function automatic logic [32:0] model(input logic [1:0] t, input logic [31:0] v,
                                        input logic c, input int n);
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic drive(input logic [1:0] s, input logic [1:0] t, input logic [31:0] v,
                       input logic c, input logic [4:0] ia, input logic [7:0] ra,
                       input logic [7:0] ri, input logic [3:0] rf);
    @(negedge clk_i);
    src_i = s; type_i = t; value_i = v; carry_i = c;
    imm_amt_i = ia; reg_amt_i = ra; rot_imm_i = ri; rot_fld_i = rf;
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] ev, input logic ec);
    n_chk++;
    if (operand_o !== ev || carry_o !== ec) begin
      n_err++;
      $display("FAIL %s: got operand=%h carry=%b, expected operand=%h carry=%b",
               tag, operand_o, carry_o, ev, ec);
    end
  endtask

  task automatic t_reset;
    drive(2'd0, 2'd0, 32'h0, 1'b0, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R2 reset idle inputs", 32'h0, 1'b0);
  endtask

  task automatic t_imm_basic;
    drive(2'd0, 2'd0, 32'hF000_000F, 1'b0, 5'd4, 8'd0, 8'd0, 4'd0);
    chk("R1 imm lsl 4", 32'h0000_00F0, 1'b1);
    drive(2'd0, 2'd1, 32'h0000_0018, 1'b0, 5'd4, 8'd0, 8'd0, 4'd0);
    chk("R1 imm lsr 4", 32'h0000_0001, 1'b1);
    drive(2'd0, 2'd2, 32'h8000_0000, 1'b0, 5'd31, 8'd0, 8'd0, 4'd0);
    chk("R1 imm asr 31", 32'hFFFF_FFFF, 1'b0);
    drive(2'd0, 2'd3, 32'h0000_001F, 1'b0, 5'd4, 8'd0, 8'd0, 4'd0);
    chk("R1 imm ror 4", 32'hF000_0001, 1'b1);
    drive(2'd3, 2'd0, 32'hF000_000F, 1'b0, 5'd4, 8'd0, 8'hFF, 4'd3);
    chk("R1 reserved source as immediate", 32'h0000_00F0, 1'b1);
  endtask

  task automatic t_imm_zero;
    drive(2'd0, 2'd0, 32'h1234_5678, 1'b1, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R2 imm lsl 0 pass", 32'h1234_5678, 1'b1);
    drive(2'd0, 2'd1, 32'h8000_0001, 1'b0, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R3 imm lsr 0 means 32", 32'h0, 1'b1);
    drive(2'd0, 2'd2, 32'h8000_0000, 1'b0, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R3 imm asr 0 negative", 32'hFFFF_FFFF, 1'b1);
    drive(2'd0, 2'd2, 32'h7FFF_FFFF, 1'b1, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R3 imm asr 0 positive", 32'h0, 1'b0);
    drive(2'd0, 2'd3, 32'h0000_0003, 1'b1, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R4 rrx carry in", 32'h8000_0001, 1'b1);
    drive(2'd0, 2'd3, 32'h8000_0002, 1'b0, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R4 rrx carry clear", 32'h4000_0001, 1'b0);
  endtask

  task automatic t_reg_large;
    drive(2'd1, 2'd0, 32'h0000_0001, 1'b0, 5'd0, 8'd32, 8'd0, 4'd0);
    chk("R6 reg lsl 32", 32'h0, 1'b1);
    drive(2'd1, 2'd0, 32'hFFFF_FFFF, 1'b1, 5'd0, 8'd33, 8'd0, 4'd0);
    chk("R6 reg lsl 33", 32'h0, 1'b0);
    drive(2'd1, 2'd1, 32'h8000_0000, 1'b0, 5'd0, 8'd32, 8'd0, 4'd0);
    chk("R6 reg lsr 32", 32'h0, 1'b1);
    drive(2'd1, 2'd1, 32'hFFFF_FFFF, 1'b1, 5'd0, 8'd255, 8'd0, 4'd0);
    chk("R5 R6 reg lsr 255", 32'h0, 1'b0);
    drive(2'd1, 2'd2, 32'h8000_0000, 1'b0, 5'd0, 8'd200, 8'd0, 4'd0);
    chk("R7 reg asr 200", 32'hFFFF_FFFF, 1'b1);
    drive(2'd1, 2'd2, 32'h4000_0000, 1'b1, 5'd0, 8'd40, 8'd0, 4'd0);
    chk("R7 reg asr 40 positive", 32'h0, 1'b0);
    drive(2'd1, 2'd1, 32'hF000_0000, 1'b1, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R2 reg amount 0", 32'hF000_0000, 1'b1);
  endtask

  task automatic t_reg_ror;
    drive(2'd1, 2'd3, 32'hA5A5_0000, 1'b1, 5'd0, 8'd0, 8'd0, 4'd0);
    chk("R8 reg ror 0", 32'hA5A5_0000, 1'b1);
    drive(2'd1, 2'd3, 32'h8000_0001, 1'b0, 5'd0, 8'd32, 8'd0, 4'd0);
    chk("R8 reg ror 32", 32'h8000_0001, 1'b1);
    drive(2'd1, 2'd3, 32'h0000_0001, 1'b1, 5'd0, 8'd64, 8'd0, 4'd0);
    chk("R8 reg ror 64", 32'h0000_0001, 1'b0);
    drive(2'd1, 2'd3, 32'h0000_001F, 1'b0, 5'd0, 8'd36, 8'd0, 4'd0);
    chk("R8 reg ror 36", 32'hF000_0001, 1'b1);
  endtask

  task automatic t_rot_imm;
    drive(2'd2, 2'd1, 32'hDEAD_BEEF, 1'b0, 5'd7, 8'd9, 8'hFF, 4'd4);
    chk("R9 rot imm ff by 8", 32'hFF00_0000, 1'b1);
    drive(2'd2, 2'd2, 32'hFFFF_FFFF, 1'b0, 5'd0, 8'd0, 8'h80, 4'd0);
    chk("R9 rot imm field 0", 32'h0000_0080, 1'b0);
    drive(2'd2, 2'd0, 32'h1234_5678, 1'b1, 5'd0, 8'd0, 8'h03, 4'd1);
    chk("R9 rot imm by 2", 32'hC000_0000, 1'b1);
    drive(2'd2, 2'd3, 32'h0, 1'b1, 5'd0, 8'd0, 8'h01, 4'd15);
    chk("R9 rot imm by 30", 32'h0000_0004, 1'b0);
  endtask

  task automatic t_sweep;
    logic [32:0] e;
    int n;
    for (int t = 0; t < 4; t++) begin
      for (int a = 1; a < 32; a++) begin
        drive(2'd0, 2'(t), 32'hC35A_96A1, 1'b1, 5'(a), 8'd0, 8'd0, 4'd0);
        e = model(2'(t), 32'hC35A_96A1, 1'b1, a);
        chk("R1 imm sweep", e[31:0], e[32]);
      end
    end
    for (int t = 0; t < 4; t++) begin
      for (int a = 0; a < 256; a += 7) begin
        n = a;
        if (t < 2 && n > 33) n = 33;
        if (t == 2 && n > 32) n = 32;
        if (t == 3 && n != 0) n = (n % 32 == 0) ? 32 : n % 32;
        drive(2'd1, 2'(t), 32'h9C3B_5A61, 1'b0, 5'd0, 8'(a), 8'd0, 4'd0);
        e = model(2'(t), 32'h9C3B_5A61, 1'b0, n);
        chk("R5 reg sweep", e[31:0], e[32]);
      end
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    t_reset();
    t_imm_basic();
    t_imm_zero();
    t_reg_large();
    t_reg_ror();
    t_rot_imm();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule